// File: doc/BRIEF.md
# DMA Dispatcher Control and Status Registers

This block is the register slave that software uses to watch and steer a scatter-gather DMA dispatcher. It presents five 32-bit words on a simple write/read port. The first is a status word that combines live levels from the descriptor and response FIFOs with sticky event flags. The others are a control word, the read and write FIFO fill levels, the response FIFO fill level, and the read and write sequence numbers. Reads are combinational and have no side effects. Sticky status flags are cleared by writing ones to them.

The engine reports completions, errors and early terminations as single-cycle event pulses. Any of these marks an interrupt as pending. Depending on two policy bits in the control word, an error or an early termination also latches a stop that halts the engine. The interrupt output is the pending flag gated by a global enable.

Writing the reset bit of the control word starts a self-timed soft reset. While it runs, a resetting flag is visible and the FIFOs are told to flush. At its end, the control word and all sticky flags are zero.

Top module: `dma_csr_top`

## Requirements
- R1: After the reset input is released, the control word (offset 0x04) reads 0, the status word (offset 0x00) shows only the live bits, and irq, engStop and fifoFlush are 0.
- R2: Offset 0x08 reads {wrFill, rdFill} in bits 31:16 and 15:0. Offset 0x0C reads respFill in bits 15:0. Offset 0x10 reads {wrSeq, rdSeq}. Any other offset reads 0.
- R3: The following status bits follow their inputs in the same cycle: bit 0 busy, bit 1 descriptor FIFO empty, bit 2 descriptor FIFO full, bit 3 response FIFO empty, bit 4 response FIFO full. Status bit 5 (stopped) equals engStop.
- R4: Status bits 7 (stopped on error), 8 (stopped on early termination) and 9 (interrupt pending) are sticky. A status write clears exactly the sticky bits written as one and leaves the live bits unchanged. If an event and a clear of the same bit fall in one cycle, the event wins.
- R5: Any of evtDone, evtErr or evtEarly sets bit 9 on the next cycle. evtErr also sets bit 7 only when control bit 2 (stop on error) is set.
- R6: evtEarly sets bit 8 only when control bit 3 (stop on early termination) is set.
- R7: irq is high exactly when bit 9 is set and control bit 4 (global interrupt enable) is set.
- R8: A control write with bit 1 set starts a soft reset lasting RST_CYCLES cycles. During it, status bit 6, control bit 1 and fifoFlush read 1. Afterwards, the control word and status bits 7 to 9 are 0.
- R9: While the soft reset runs, register writes and engine events are ignored.
- R10: Control bits 0, 2, 3, 4 and 5 read back as written, and all other bits read 0. Control bit 5 drives descHalt. engStop is the OR of control bit 0 and status bits 7 and 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | ADDR_W | Byte offset of the accessed word |
| wrEn | input | 1 | Write strobe |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for regAddr |
| engBusy | input | 1 | Engine is moving data |
| descEmpty | input | 1 | Descriptor FIFO empty |
| descFull | input | 1 | Descriptor FIFO full |
| respEmpty | input | 1 | Response FIFO empty |
| respFull | input | 1 | Response FIFO full |
| wrFill | input | FILL_W | Write descriptor FIFO level |
| rdFill | input | FILL_W | Read descriptor FIFO level |
| respFill | input | FILL_W | Response FIFO level |
| wrSeq | input | 16 | Write sequence number |
| rdSeq | input | 16 | Read sequence number |
| evtDone | input | 1 | Transfer completed pulse |
| evtErr | input | 1 | Error response pulse |
| evtEarly | input | 1 | Early termination pulse |
| irq | output | 1 | Interrupt request |
| engStop | output | 1 | Stop request to the engine |
| descHalt | output | 1 | Halt descriptor processing |
| fifoFlush | output | 1 | FIFO flush during soft reset |

## Verification
The hardest situations to reach are the ones where two actions land in the same cycle. One is an engine event coinciding with a write-one-to-clear of the same sticky bit. The other is writes and events arriving while the soft reset counts down. The bench reaches both by driving the event pulses and the write on the same falling edge, and by issuing a control write and an error pulse in the first cycle after the reset starts. It then reads the status and control words back once the resetting flag has dropped.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;
  // Word offsets decoded by software
  localparam logic [7:0] OFS_STAT = 8'h00;
  localparam logic [7:0] OFS_CTRL = 8'h04;
  localparam logic [7:0] OFS_FILL = 8'h08;
  localparam logic [7:0] OFS_RESP = 8'h0C;
  localparam logic [7:0] OFS_SEQ  = 8'h10;

  // Control bit positions
  localparam int C_STOP  = 0;
  localparam int C_RST   = 1;
  localparam int C_SOERR = 2;
  localparam int C_SOEAR = 3;
  localparam int C_GIE   = 4;
  localparam int C_HALT  = 5;
  localparam int CTRL_W  = 6;

  // Sticky status bit positions
  localparam int S_ERR  = 7;
  localparam int S_EAR  = 8;
  localparam int S_PEND = 9;

  typedef struct packed {
    logic ctrlWr;
    logic statWr;
    logic resetGo;
    logic resetting;
  } csr_strobe_t;
endpackage

// File: rtl/dma_csr_ctrl.sv
module dma_csr_ctrl
  import dma_csr_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrEn,
  input  logic [31:0]       wrData,
  output csr_strobe_t       stb
);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);

  logic [CNT_W-1:0] rstCnt;
  logic             busyRst;
  logic             hitCtrl;
  logic             hitStat;

  assign busyRst = (rstCnt != '0);
  assign hitCtrl = wrEn && (regAddr == OFS_CTRL[ADDR_W-1:0]) && !busyRst;
  assign hitStat = wrEn && (regAddr == OFS_STAT[ADDR_W-1:0]) && !busyRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstCnt <= '0;
    end else if (hitCtrl && wrData[C_RST]) begin
      rstCnt <= CNT_W'(RST_CYCLES);
    end else if (busyRst) begin
      rstCnt <= rstCnt - 1'b1;
    end
  end

  always_comb begin
    stb.ctrlWr    = hitCtrl;
    stb.statWr    = hitStat;
    stb.resetGo   = hitCtrl && wrData[C_RST];
    stb.resetting = busyRst;
  end
endmodule

// File: rtl/dma_csr_dpath.sv
module dma_csr_dpath
  import dma_csr_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int FILL_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  csr_strobe_t       stb,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  input  logic              engBusy,
  input  logic              descEmpty,
  input  logic              descFull,
  input  logic              respEmpty,
  input  logic              respFull,
  input  logic [FILL_W-1:0] wrFill,
  input  logic [FILL_W-1:0] rdFill,
  input  logic [FILL_W-1:0] respFill,
  input  logic [15:0]       wrSeq,
  input  logic [15:0]       rdSeq,
  input  logic              evtDone,
  input  logic              evtErr,
  input  logic              evtEarly,
  output logic [CTRL_W-1:0] ctrlBits,
  output logic              irq,
  output logic              engStop,
  output logic              descHalt,
  output logic              fifoFlush
);
  logic [CTRL_W-1:0] ctrlQ;
  logic errQ, earQ, pendQ;
  logic clrErr, clrEar, clrPend;
  logic [31:0] statWord, ctrlWord;

  assign clrErr  = stb.statWr && wrData[S_ERR];
  assign clrEar  = stb.statWr && wrData[S_EAR];
  assign clrPend = stb.statWr && wrData[S_PEND];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
      errQ  <= 1'b0;
      earQ  <= 1'b0;
      pendQ <= 1'b0;
    end else if (stb.resetGo || stb.resetting) begin
      ctrlQ <= '0;
      errQ  <= 1'b0;
      earQ  <= 1'b0;
      pendQ <= 1'b0;
    end else begin
      if (stb.ctrlWr) begin
        ctrlQ <= wrData[CTRL_W-1:0] & ~(CTRL_W'(1) << C_RST);
      end
      errQ  <= (errQ && !clrErr) || (evtErr && ctrlQ[C_SOERR]);
      earQ  <= (earQ && !clrEar) || (evtEarly && ctrlQ[C_SOEAR]);
      pendQ <= (pendQ && !clrPend) || evtDone || evtErr || evtEarly;
    end
  end

  assign engStop   = ctrlQ[C_STOP] || errQ || earQ;
  assign descHalt  = ctrlQ[C_HALT];
  assign irq       = pendQ && ctrlQ[C_GIE];
  assign fifoFlush = stb.resetting;
  assign ctrlBits  = ctrlQ;

  always_comb begin
    statWord = '0;
    statWord[0] = engBusy;
    statWord[1] = descEmpty;
    statWord[2] = descFull;
    statWord[3] = respEmpty;
    statWord[4] = respFull;
    statWord[5] = engStop;
    statWord[6] = stb.resetting;
    statWord[S_ERR]  = errQ;
    statWord[S_EAR]  = earQ;
    statWord[S_PEND] = pendQ;
    ctrlWord = 32'(ctrlQ);
    ctrlWord[C_RST] = stb.resetting;
  end

  always_comb begin
    case (regAddr)
      OFS_STAT[ADDR_W-1:0]: rdData = statWord;
      OFS_CTRL[ADDR_W-1:0]: rdData = ctrlWord;
      OFS_FILL[ADDR_W-1:0]: rdData = {16'(wrFill), 16'(rdFill)};
      OFS_RESP[ADDR_W-1:0]: rdData = 32'(respFill);
      OFS_SEQ[ADDR_W-1:0]:  rdData = {wrSeq, rdSeq};
      default:              rdData = '0;
    endcase
  end
endmodule

// File: rtl/dma_csr_top.sv
module dma_csr_top
  import dma_csr_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int FILL_W     = 16,
  parameter int RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrEn,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  input  logic              engBusy,
  input  logic              descEmpty,
  input  logic              descFull,
  input  logic              respEmpty,
  input  logic              respFull,
  input  logic [FILL_W-1:0] wrFill,
  input  logic [FILL_W-1:0] rdFill,
  input  logic [FILL_W-1:0] respFill,
  input  logic [15:0]       wrSeq,
  input  logic [15:0]       rdSeq,
  input  logic              evtDone,
  input  logic              evtErr,
  input  logic              evtEarly,
  output logic              irq,
  output logic              engStop,
  output logic              descHalt,
  output logic              fifoFlush
);
  csr_strobe_t       stb;
  logic [CTRL_W-1:0] ctrlBits;

  dma_csr_ctrl #(.ADDR_W(ADDR_W), .RST_CYCLES(RST_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn),
    .wrData(wrData), .stb(stb)
  );

  dma_csr_dpath #(.ADDR_W(ADDR_W), .FILL_W(FILL_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .regAddr(regAddr),
    .wrData(wrData), .rdData(rdData),
    .engBusy(engBusy), .descEmpty(descEmpty), .descFull(descFull),
    .respEmpty(respEmpty), .respFull(respFull),
    .wrFill(wrFill), .rdFill(rdFill), .respFill(respFill),
    .wrSeq(wrSeq), .rdSeq(rdSeq),
    .evtDone(evtDone), .evtErr(evtErr), .evtEarly(evtEarly),
    .ctrlBits(ctrlBits), .irq(irq), .engStop(engStop),
    .descHalt(descHalt), .fifoFlush(fifoFlush)
  );
endmodule

// File: rtl/dma_csr_chk.sv
module dma_csr_chk
  import dma_csr_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int RST_CYCLES = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic              wrEn,
  input logic [31:0]       wrData,
  input logic              evtDone,
  input logic              evtErr,
  input logic              evtEarly,
  input logic [CTRL_W-1:0] ctrlBits,
  input logic              irq,
  input logic              engStop,
  input logic              fifoFlush
);
  localparam int CNT_W = $clog2(RST_CYCLES + 2);
  logic [CNT_W-1:0] flushRun;
  logic ctrlHit, statHit, anyEvt;

  assign ctrlHit = wrEn && (regAddr == OFS_CTRL[ADDR_W-1:0]) && !fifoFlush;
  assign statHit = wrEn && (regAddr == OFS_STAT[ADDR_W-1:0]) && !fifoFlush;
  assign anyEvt  = evtDone || evtErr || evtEarly;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      flushRun <= '0;
    else if (!fifoFlush)
      flushRun <= '0;
    else if (flushRun <= CNT_W'(RST_CYCLES))
      flushRun <= flushRun + 1'b1;
  end

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlHit && !wrData[C_GIE] && !wrData[C_RST]) |=> !irq);

  // R5
  err_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtErr && ctrlBits[C_SOERR] && !fifoFlush && !ctrlHit) |=> engStop);

  // R4
  w1c_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statHit && wrData[S_PEND] && !anyEvt) |=> !irq);

  // R8
  reset_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlHit && wrData[C_RST]) |=> (fifoFlush && ctrlBits == '0 && !irq));

  // R9
  reset_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoFlush |-> (ctrlBits == '0 && !irq && !engStop));

  // R8
  reset_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushRun <= CNT_W'(RST_CYCLES));
endmodule

bind dma_csr_top dma_csr_chk #(.ADDR_W(ADDR_W), .RST_CYCLES(RST_CYCLES)) u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn), .wrData(wrData),
  .evtDone(evtDone), .evtErr(evtErr), .evtEarly(evtEarly),
  .ctrlBits(ctrlBits), .irq(irq), .engStop(engStop), .fifoFlush(fifoFlush)
);

// File: tb/test_dma_csr_top.sv
module test_dma_csr_top;
  localparam int RST = 4;

  typedef struct packed {
    logic        wr;
    logic [4:0]  addr;
    logic [31:0] wdata;
    logic [2:0]  evt;    // {done, err, early}
    logic [4:0]  raddr;
    logic [31:0] exp;
    logic        expIrq;
    logic        expStop;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 5'h00, 32'h0,          3'b000, 5'h08, 32'h0003_0005, 1'b0, 1'b0}, // R2
    '{1'b0, 5'h00, 32'h0,          3'b000, 5'h0C, 32'h0000_0002, 1'b0, 1'b0}, // R2
    '{1'b0, 5'h00, 32'h0,          3'b000, 5'h10, 32'h0012_0034, 1'b0, 1'b0}, // R2
    '{1'b1, 5'h04, 32'h14,         3'b000, 5'h04, 32'h0000_0014, 1'b0, 1'b0}, // R10
    '{1'b0, 5'h00, 32'h0,          3'b100, 5'h00, 32'h0000_020A, 1'b1, 1'b0}, // R5 R7
    '{1'b1, 5'h00, 32'h200,        3'b000, 5'h00, 32'h0000_000A, 1'b0, 1'b0}, // R4
    '{1'b0, 5'h00, 32'h0,          3'b010, 5'h00, 32'h0000_02AA, 1'b1, 1'b1}, // R5
    '{1'b1, 5'h00, 32'h080,        3'b000, 5'h00, 32'h0000_020A, 1'b1, 1'b0}, // R4
    '{1'b1, 5'h00, 32'h200,        3'b000, 5'h00, 32'h0000_000A, 1'b0, 1'b0}, // R4
    '{1'b0, 5'h00, 32'h0,          3'b001, 5'h00, 32'h0000_020A, 1'b1, 1'b0}, // R6
    '{1'b1, 5'h04, 32'h0,          3'b000, 5'h00, 32'h0000_020A, 1'b0, 1'b0}, // R7
    '{1'b1, 5'h04, 32'hFFFF_FFD8,  3'b000, 5'h04, 32'h0000_0018, 1'b1, 1'b0}, // R10 R7
    '{1'b0, 5'h00, 32'h0,          3'b001, 5'h00, 32'h0000_032A, 1'b1, 1'b1}, // R6
    '{1'b1, 5'h00, 32'hFFFF_FFFF,  3'b000, 5'h00, 32'h0000_000A, 1'b0, 1'b0}, // R4
    '{1'b1, 5'h04, 32'h21,         3'b000, 5'h00, 32'h0000_002A, 1'b0, 1'b1}, // R10 R3
    '{1'b1, 5'h04, 32'h0,          3'b000, 5'h14, 32'h0000_0000, 1'b0, 1'b0}  // R2
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [4:0] regAddr = '0;
  logic wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic engBusy = 1'b0, descEmpty = 1'b1, descFull = 1'b0;
  logic respEmpty = 1'b1, respFull = 1'b0;
  logic [15:0] wrFill = 16'h0003, rdFill = 16'h0005, respFill = 16'h0002;
  logic [15:0] wrSeq = 16'h0012, rdSeq = 16'h0034;
  logic evtDone = 1'b0, evtErr = 1'b0, evtEarly = 1'b0;
  logic irq, engStop, descHalt, fifoFlush;

  int nTests = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dma_csr_top #(.ADDR_W(5), .FILL_W(16), .RST_CYCLES(RST)) i_dma_csr_top (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .engBusy(engBusy), .descEmpty(descEmpty),
    .descFull(descFull), .respEmpty(respEmpty), .respFull(respFull),
    .wrFill(wrFill), .rdFill(rdFill), .respFill(respFill),
    .wrSeq(wrSeq), .rdSeq(rdSeq), .evtDone(evtDone), .evtErr(evtErr),
    .evtEarly(evtEarly), .irq(irq), .engStop(engStop),
    .descHalt(descHalt), .fifoFlush(fifoFlush)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Called at a falling edge; drives for one cycle and returns at the next falling edge.
  task automatic step(input logic wr, input logic [4:0] a, input logic [31:0] d,
                      input logic [2:0] evt, input logic [4:0] ra);
    wrEn = wr; wrData = d; evtDone = evt[2]; evtErr = evt[1]; evtEarly = evt[0];
    regAddr = wr ? a : ra;
    @(posedge clk);
    #1 regAddr = ra;
    wrEn = 1'b0; evtDone = 1'b0; evtErr = 1'b0; evtEarly = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    regAddr = 5'h04; #1 check("R1 ctrl", rdData, 32'h0);
    regAddr = 5'h00; #1 check("R1 status", rdData, 32'h0000_000A);
    check("R1 outputs", {29'b0, irq, engStop, fifoFlush}, 32'h0);
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].wr, VECS[i].addr, VECS[i].wdata, VECS[i].evt, VECS[i].raddr);
      check($sformatf("vec%0d data", i), rdData, VECS[i].exp);
      check($sformatf("vec%0d irq R7", i), 32'(irq), 32'(VECS[i].expIrq));
      check($sformatf("vec%0d stop R10", i), 32'(engStop), 32'(VECS[i].expStop));
    end

    // R3 live bits follow inputs in the same cycle
    engBusy = 1'b1; respFull = 1'b1; descFull = 1'b1; regAddr = 5'h00; #1;
    check("R3 live", rdData, 32'h0000_001F);
    engBusy = 1'b0; respFull = 1'b0; descFull = 1'b0; #1;
    check("R3 live back", rdData, 32'h0000_000A);

    // R10 descHalt
    step(1'b1, 5'h04, 32'h20, 3'b000, 5'h04);
    check("R10 descHalt", 32'(descHalt), 32'h1);
    check("R10 readback", rdData, 32'h20);

    // R4 set wins over same-cycle clear
    step(1'b1, 5'h04, 32'h10, 3'b000, 5'h00);
    step(1'b0, 5'h00, 32'h0, 3'b100, 5'h00);
    step(1'b1, 5'h00, 32'h200, 3'b100, 5'h00);
    check("R4 set wins", rdData, 32'h0000_020A);

    // R5 error without stop-on-error sets only pending
    step(1'b1, 5'h00, 32'h200, 3'b000, 5'h00);
    step(1'b0, 5'h00, 32'h0, 3'b010, 5'h00);
    check("R5 no policy", rdData, 32'h0000_020A);
    check("R5 no stop", 32'(engStop), 32'h0);

    // R8 R9 soft reset
    step(1'b1, 5'h04, 32'h1C, 3'b000, 5'h00);
    step(1'b0, 5'h00, 32'h0, 3'b011, 5'h00);
    check("R8 pre", rdData, 32'h0000_03AA);
    step(1'b1, 5'h04, 32'h02, 3'b000, 5'h00);
    for (int c = 0; c < RST; c++) begin
      check($sformatf("R8 resetting c%0d", c), rdData & 32'h40, 32'h40);
      check("R8 flush", 32'(fifoFlush), 32'h1);
      if (c == 0) begin
        regAddr = 5'h04; #1 check("R8 ctrl bit", rdData, 32'h2);
        step(1'b1, 5'h04, 32'h11, 3'b110, 5'h00);
      end else begin
        step(1'b0, 5'h00, 32'h0, 3'b000, 5'h00);
      end
    end
    check("R8 done status", rdData, 32'h0000_000A);
    check("R8 done flush", 32'(fifoFlush), 32'h0);
    regAddr = 5'h04; #1 check("R9 ctrl ignored", rdData, 32'h0);
    check("R9 outputs", {30'b0, irq, engStop}, 32'h0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule